// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block gathers level-sensitive status lines from three families of protection hardware into 32-bit status words that a register bank can return on reads. The families are memory protection controllers, peripheral protection controllers and master security controllers. Each status line is sampled into a flop on every clock. A bit in a status word is set while its source line is high and clears when the line drops. Nothing stored is sticky.

For the master security controllers the block also holds an enable word and raises one registered, combined interrupt. It holds two per-controller output groups loaded by register writes: a clear group and a non-secure group. The surrounding register bank decodes addresses. It presents write data with one strobe per writable register and reads the status and enable words straight from the output ports. The status words have no write path, so any write aimed at them has no effect on them.

Reset is asynchronous and active low. Its release is expected to be synchronised to `clk` outside the block.

Top module: `secagg_top`

## Requirements
- R1: While `rst_n` is low, every output is zero. After reset, every status word, the enable word, the clear group, the non-secure group and the interrupt stay zero until an input or a write changes them.
- R2: Internal memory-protection line n appears at bit n of `mpc_status`. Expansion memory-protection line n appears at bit n+16. Each bit shows the line's level from the previous clock edge.
- R3: Expansion master-security line n appears at bit n+16 of `msc_status`, one clock edge after it is sampled.
- R4: Peripheral-protection line k appears at `ppc_status` bit `PPC_MAP[8k+:8]`, one clock edge after it is sampled. With the default map, lines 0 to 9 land on bits 0, 1, 4, 5, 6, 7, 20, 21, 22 and 23.
- R5: Every status-word bit that no source line is mapped to reads zero.
- R6: A cycle with `wr_msc_en` high loads the whole of `wr_data` into `msc_en`. The word then holds until the next such write.
- R7: `msc_irq` is high exactly when, one edge earlier, the bitwise AND of `msc_status` and `msc_en` was nonzero. A source line therefore reaches the interrupt two edges after it is sampled.
- R8: A cycle with `wr_msc_clr` high sets `msc_clr[i]` to `wr_data[16+i]` at the next edge. The group holds that value until the next clear write.
- R9: A cycle with `wr_msc_ns` high sets `msc_ns[i]` to `wr_data[16+i]` at the next edge. The group holds that value until the next non-secure write.
- R10: The three write strobes act independently. Any subset may be high in the same cycle, and each loads only its own register. No write changes any status word.
- R11: Status bits follow their lines level for level. A bit clears on the edge after its line drops, even if the clear group holds ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mpc_int_st | input | N_MPC_INT | Internal memory-protection status lines |
| mpc_exp_st | input | N_MPC_EXP | Expansion memory-protection status lines |
| msc_exp_st | input | N_MSC | Expansion master-security status lines |
| ppc_st | input | N_PPC | Peripheral-protection status lines, one per controller |
| wr_data | input | 32 | Write data from the register bank |
| wr_msc_en | input | 1 | Write strobe for the master-security enable word |
| wr_msc_clr | input | 1 | Write strobe for the master-security clear group |
| wr_msc_ns | input | 1 | Write strobe for the master-security non-secure group |
| mpc_status | output | 32 | Packed memory-protection status word |
| ppc_status | output | 32 | Packed peripheral-protection status word |
| msc_status | output | 32 | Packed master-security status word |
| msc_en | output | 32 | Master-security enable word |
| msc_irq | output | 1 | Registered combined master-security interrupt |
| msc_clr | output | N_MSC | Per-controller master-security clear lines |
| msc_ns | output | N_MSC | Per-controller master-security non-secure lines |

## Verification
The bench uses the default parameters: one internal and four expansion memory-protection lines, four master-security lines, and ten peripheral-protection lines on the split default map. These values are small enough to sweep in full. All 32 memory-protection patterns and all 1024 peripheral-protection patterns are applied. Every pairing of the 16 master-security status patterns with the 16 enable patterns is also run, and the packed words and the interrupt are compared with values derived arithmetically from the bit positions. All 16 values of the clear and non-secure fields are written with noise in the other bits of `wr_data`, which exposes any off-by-one in the field position and any failure to hold between writes.

// File: rtl/secagg_pkg.sv
package secagg_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned EXP_BASE = 16;
  localparam int unsigned POS_W    = 8;
  localparam int unsigned MAX_SRC  = 32;
  localparam int unsigned MAP_W    = MAX_SRC * POS_W;

  // Map of n_all sources: the first n_lo go to bits 0.., the rest to EXP_BASE..
  function automatic logic [MAP_W-1:0] split_map(int unsigned n_lo, int unsigned n_all);
    logic [MAP_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_SRC; i++) begin
      if (i < n_all) begin
        if (i < n_lo) m[i*POS_W +: POS_W] = POS_W'(i);
        else          m[i*POS_W +: POS_W] = POS_W'(EXP_BASE + i - n_lo);
      end
    end
    return m;
  endfunction

  // Word mask of the bit positions a map uses
  function automatic logic [WORD_W-1:0] map_mask(logic [MAP_W-1:0] m, int unsigned n);
    logic [WORD_W-1:0] k;
    k = '0;
    for (int unsigned i = 0; i < MAX_SRC; i++) begin
      if (i < n) k[m[i*POS_W +: 5]] = 1'b1;
    end
    return k;
  endfunction
endpackage

// File: rtl/secagg_pack_reg.sv
module secagg_pack_reg
  import secagg_pkg::*;
#(
  parameter int unsigned      N       = 4,
  parameter logic [MAP_W-1:0] POS_MAP = split_map(0, 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src,
  output logic [WORD_W-1:0] word_q
);
  localparam logic [WORD_W-1:0] USED = map_mask(POS_MAP, N);

  logic [WORD_W-1:0] word_d;

  // Next state: scatter each sampled line to its mapped bit
  always_comb begin
    word_d = '0;
    for (int unsigned i = 0; i < N; i++) begin
      word_d[POS_MAP[i*POS_W +: 5]] = src[i];
    end
  end

  // Register: level sampling every cycle, no write path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  // Each mapped bit equals its source one edge earlier (R2, R3, R4, R11)
  for (genvar g = 0; g < N; g++) begin : g_bit_chk
    localparam int unsigned P = POS_MAP[g*POS_W +: 5];
    a_r11_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (word_q[P] == $past(src[g])));
  end

  a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q & ~USED) == '0);
endmodule

// File: rtl/secagg_msc_ctrl.sv
module secagg_msc_ctrl
  import secagg_pkg::*;
#(
  parameter int unsigned N_MSC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              wr_clr,
  input  logic              wr_ns,
  input  logic [WORD_W-1:0] stat_q,
  output logic [WORD_W-1:0] en_q,
  output logic [N_MSC-1:0]  clr_q,
  output logic [N_MSC-1:0]  ns_q,
  output logic              irq_q
);
  logic [N_MSC-1:0] field_d;
  logic             irq_d;

  // Next state
  always_comb begin
    field_d = wr_data[EXP_BASE +: N_MSC];
    irq_d   = |(stat_q & en_q);
  end

  // Registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      clr_q <= '0;
      ns_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en)  en_q  <= wr_data;
      if (wr_clr) clr_q <= field_d;
      if (wr_ns)  ns_q  <= field_d;
      irq_q <= irq_d;
    end
  end

  a_r6_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
  a_r7_irq_combine: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == $past((stat_q & en_q) != '0)));
  a_r8_clr_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (clr_q == $past(wr_data[EXP_BASE +: N_MSC])));
  a_r8_clr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> $stable(clr_q));
  a_r9_ns_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ns |=> (ns_q == $past(wr_data[EXP_BASE +: N_MSC])));
  a_r9_ns_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ns |=> $stable(ns_q));
endmodule

// File: rtl/secagg_top.sv
module secagg_top
  import secagg_pkg::*;
#(
  parameter int unsigned      N_MPC_INT = 1,
  parameter int unsigned      N_MPC_EXP = 4,
  parameter int unsigned      N_MSC     = 4,
  parameter int unsigned      N_PPC     = 10,
  parameter logic [MAP_W-1:0] PPC_MAP   = MAP_W'(80'h17161514070605040100)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MPC_INT-1:0] mpc_int_st,
  input  logic [N_MPC_EXP-1:0] mpc_exp_st,
  input  logic [N_MSC-1:0]     msc_exp_st,
  input  logic [N_PPC-1:0]     ppc_st,
  input  logic [31:0]          wr_data,
  input  logic                 wr_msc_en,
  input  logic                 wr_msc_clr,
  input  logic                 wr_msc_ns,
  output logic [31:0]          mpc_status,
  output logic [31:0]          ppc_status,
  output logic [31:0]          msc_status,
  output logic [31:0]          msc_en,
  output logic                 msc_irq,
  output logic [N_MSC-1:0]     msc_clr,
  output logic [N_MSC-1:0]     msc_ns
);
  localparam int unsigned      N_MPC   = N_MPC_INT + N_MPC_EXP;
  localparam logic [MAP_W-1:0] MPC_MAP = split_map(N_MPC_INT, N_MPC);
  localparam logic [MAP_W-1:0] MSC_MAP = split_map(0, N_MSC);

  logic [N_MPC-1:0] mpc_src;
  assign mpc_src = {mpc_exp_st, mpc_int_st};

  secagg_pack_reg #(.N(N_MPC), .POS_MAP(MPC_MAP)) u_mpc (
    .clk(clk), .rst_n(rst_n), .src(mpc_src), .word_q(mpc_status));

  secagg_pack_reg #(.N(N_PPC), .POS_MAP(PPC_MAP)) u_ppc (
    .clk(clk), .rst_n(rst_n), .src(ppc_st), .word_q(ppc_status));

  secagg_pack_reg #(.N(N_MSC), .POS_MAP(MSC_MAP)) u_msc (
    .clk(clk), .rst_n(rst_n), .src(msc_exp_st), .word_q(msc_status));

  secagg_msc_ctrl #(.N_MSC(N_MSC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en(wr_msc_en), .wr_clr(wr_msc_clr), .wr_ns(wr_msc_ns),
    .stat_q(msc_status), .en_q(msc_en), .clr_q(msc_clr), .ns_q(msc_ns),
    .irq_q(msc_irq));

  // Writes never disturb the stored status (R10)
  a_r10_status_write_free: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msc_clr && $stable(msc_exp_st)) |=> (msc_status == $past(msc_status) ||
      msc_status == {{(32-EXP_BASE-N_MSC){1'b0}}, $past(msc_exp_st), {EXP_BASE{1'b0}}}));

  // Reset clears everything (R1)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (mpc_status == '0 && ppc_status == '0 &&
        msc_status == '0 && msc_en == '0 && !msc_irq && msc_clr == '0 && msc_ns == '0);
    end
  end
endmodule

// File: tb/secagg_top_bench.sv
module secagg_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [0:0]  mpc_int_st;
  logic [3:0]  mpc_exp_st;
  logic [3:0]  msc_exp_st;
  logic [9:0]  ppc_st;
  logic [31:0] wr_data;
  logic        wr_msc_en, wr_msc_clr, wr_msc_ns;
  logic [31:0] mpc_status, ppc_status, msc_status, msc_en;
  logic        msc_irq;
  logic [3:0]  msc_clr, msc_ns;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  secagg_top u_secagg_top (
    .clk(clk), .rst_n(rst_n), .mpc_int_st(mpc_int_st), .mpc_exp_st(mpc_exp_st),
    .msc_exp_st(msc_exp_st), .ppc_st(ppc_st), .wr_data(wr_data),
    .wr_msc_en(wr_msc_en), .wr_msc_clr(wr_msc_clr), .wr_msc_ns(wr_msc_ns),
    .mpc_status(mpc_status), .ppc_status(ppc_status), .msc_status(msc_status),
    .msc_en(msc_en), .msc_irq(msc_irq), .msc_clr(msc_clr), .msc_ns(msc_ns));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ppc_expect(logic [9:0] v);
    int pos [10] = '{0, 1, 4, 5, 6, 7, 20, 21, 22, 23};
    logic [31:0] w = '0;
    for (int i = 0; i < 10; i++) w[pos[i]] = v[i];
    return w;
  endfunction

  task automatic all_zero(input string tag);
    chk({tag, " mpc"}, mpc_status, 32'h0);
    chk({tag, " ppc"}, ppc_status, 32'h0);
    chk({tag, " msc"}, msc_status, 32'h0);
    chk({tag, " en"},  msc_en, 32'h0);
    chk({tag, " irq"}, {31'h0, msc_irq}, 32'h0);
    chk({tag, " clr"}, {28'h0, msc_clr}, 32'h0);
    chk({tag, " ns"},  {28'h0, msc_ns}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mpc_int_st = '0; mpc_exp_st = '0; msc_exp_st = '0; ppc_st = '0;
    wr_data = '0; wr_msc_en = 1'b0; wr_msc_clr = 1'b0; wr_msc_ns = 1'b0;
    repeat (3) @(negedge clk);
    all_zero("R1 in reset");
    rst_n = 1'b1;
    step();
    all_zero("R1 after reset");

    // R2 exhaustive memory-protection sweep
    for (int v = 0; v < 32; v++) begin
      mpc_int_st = v[0:0];
      mpc_exp_st = v[4:1];
      step();
      chk("R2 mpc packing", mpc_status, {12'h0, v[4:1], 15'h0, v[0]});
    end
    chk("R5 mpc unused bits", mpc_status & 32'hFFF0_FFFE, 32'h0);
    mpc_int_st = '0; mpc_exp_st = '0;

    // R4 exhaustive peripheral-protection sweep
    for (int v = 0; v < 1024; v++) begin
      ppc_st = v[9:0];
      step();
      chk("R4 ppc packing", ppc_status, ppc_expect(v[9:0]));
    end
    chk("R5 ppc unused bits", ppc_status & 32'hFF0F_FF0C, 32'h0);
    ppc_st = '0;

    // R3, R6, R7: every status pattern against every enable pattern
    for (int e = 0; e < 16; e++) begin
      wr_data = {12'hC3A, e[3:0], 16'h5AA5};
      wr_msc_en = 1'b1;
      step();
      wr_msc_en = 1'b0;
      wr_data = 32'hFFFF_FFFF;
      chk("R6 enable readback", msc_en, {12'hC3A, e[3:0], 16'h5AA5});
      for (int s = 0; s < 16; s++) begin
        msc_exp_st = s[3:0];
        step();
        chk("R3 msc packing", msc_status, {12'h0, s[3:0], 16'h0});
        step();
        chk("R7 combined irq", {31'h0, msc_irq}, {31'h0, (s[3:0] & e[3:0]) != 4'h0});
      end
      chk("R6 enable held", msc_en, {12'hC3A, e[3:0], 16'h5AA5});
    end

    // R8 clear field over all values, with noise outside the field
    msc_exp_st = 4'hF;
    for (int v = 0; v < 16; v++) begin
      wr_data = {12'hA5C, v[3:0], 16'hFFFF};
      wr_msc_clr = 1'b1;
      step();
      wr_msc_clr = 1'b0;
      wr_data = 32'hFFFF_FFFF;
      chk("R8 clear load", {28'h0, msc_clr}, {28'h0, v[3:0]});
      repeat (3) step();
      chk("R8 clear hold", {28'h0, msc_clr}, {28'h0, v[3:0]});
      chk("R10 clear leaves status", msc_status, 32'h000F_0000);
      chk("R10 clear leaves ns", {28'h0, msc_ns}, 32'h0);
    end

    // R9 non-secure field over all values
    for (int v = 0; v < 16; v++) begin
      wr_data = {12'h35C, ~v[3:0], 16'h0000};
      wr_msc_ns = 1'b1;
      step();
      wr_msc_ns = 1'b0;
      wr_data = 32'h0;
      chk("R9 ns load", {28'h0, msc_ns}, {28'h0, ~v[3:0]});
      repeat (2) step();
      chk("R9 ns hold", {28'h0, msc_ns}, {28'h0, ~v[3:0]});
      chk("R10 ns leaves clear", {28'h0, msc_clr}, 32'hF);
    end

    // R11 level following even with clear outputs high
    msc_exp_st = 4'h0;
    step();
    chk("R11 msc drops", msc_status, 32'h0);
    mpc_exp_st = 4'h9; ppc_st = 10'h3FF;
    step();
    mpc_exp_st = 4'h0; ppc_st = 10'h0;
    step();
    chk("R11 mpc drops", mpc_status, 32'h0);
    chk("R11 ppc drops", ppc_status, 32'h0);

    // R10 all three strobes together
    wr_data = 32'h0006_1234;
    wr_msc_en = 1'b1; wr_msc_clr = 1'b1; wr_msc_ns = 1'b1;
    step();
    wr_msc_en = 1'b0; wr_msc_clr = 1'b0; wr_msc_ns = 1'b0;
    chk("R10 joint enable", msc_en, 32'h0006_1234);
    chk("R10 joint clear", {28'h0, msc_clr}, 32'h6);
    chk("R10 joint ns", {28'h0, msc_ns}, 32'h6);

    // R7 latency: interrupt two edges after the line
    msc_exp_st = 4'h2;
    step();
    chk("R7 irq not yet", {31'h0, msc_irq}, 32'h0);
    step();
    chk("R7 irq raised", {31'h0, msc_irq}, 32'h1);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    all_zero("R1 mid-run reset");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule